// File: doc/BRIEF.md
# Watchdog Timer with Timed Disable

This block is a watchdog that counts ticks of a separate watchdog clock, delivered as a one-cycle tick strobe in the system clock domain. When the count reaches the selected timeout, the block asks the system for a reset. Software sets it up through one 8-bit control register. The register holds a 3-bit timeout select, an enable bit and a turn-off-enable bit. The timeout is a power of two: `2^(BASE_LOG2 + sel)` ticks, so the default of `BASE_LOG2 = 14` gives a range from 16K to 2048K ticks. A kick strobe restarts the count.

Turning the watchdog on takes a single write. Turning it off is guarded, so that stray code cannot clear the enable bit:
1. A first write sets turn-off-enable and enable together.
2. A second write, which must land within four system clock cycles, clears enable.

Turn-off-enable clears itself after those four cycles. Once it has cleared, a write of zero to enable has no effect.

Top module: `wdt_timed_disable`

## Requirements
- R1: Register bits 7..5 always read as zero, and writing ones to them changes no other bit.
- R2: After reset the register reads 0x00. Its fields are turn-off-enable at bit 4, enable at bit 3 and timeout select at bits 2..0. Any write stores bits 2..0 as the new select.
- R3: A write with bit 3 set enables the watchdog at once, with no unlock step.
- R4: A write with bit 3 clear leaves enable unchanged while turn-off-enable reads 0.
- R5: A write of 0x18 followed on the next cycle by a write with bit 3 clear disables the watchdog. After the first write, bit 4 reads 1.
- R6: Turn-off-enable clears itself four cycles after the write that set it. A disabling write on the fourth cycle after it is accepted, and one on the fifth cycle is ignored.
- R7: A write with bit 4 clear closes an open unlock window at once, so a later write of 0 to enable is ignored.
- R8: While enabled, the block counts only cycles with the tick input high. It raises the reset request for exactly one cycle on the `2^(BASE_LOG2+sel)`-th tick after the count was cleared, then starts counting again from zero.
- R9: A kick clears the count, so the next request comes a full timeout after the kick.
- R10: A write that changes the timeout select clears the count.
- R11: While disabled, the block issues no reset request and holds the count at zero, so a later enable waits a full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Register read value |
| kick | input | 1 | Restart the watchdog count |
| wdTick | input | 1 | One-cycle tick of the watchdog clock |
| rstReq | output | 1 | One-cycle reset request on timeout |

## Verification
The hardest case to reach is the exact edge of the unlock window. A disabling write must be accepted on the fourth cycle after the unlocking write and refused on the fifth. The bench places the second write a counted number of idle cycles after the first, one run for each side of the boundary, and reads the register back after each. Timeout lengths are measured with a reduced `BASE_LOG2`, counting cycles from a known clearing event (enable, kick, select change), with the tick input held low for part of one run.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int SEL_W   = 3;
  localparam int REG_W   = 8;
  localparam int TOE_BIT = 4;
  localparam int EN_BIT  = 3;

  typedef struct packed {
    logic             cntClr;
    logic             cntInc;
    logic [SEL_W-1:0] limSel;
  } wdtStrobes_t;
endpackage

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             kick,
  input  logic             wdTick,
  output logic [REG_W-1:0] rdData,
  output wdtStrobes_t      strobes
);
  localparam int WIN_W = $clog2(UNLOCK_CYCLES + 1);
  localparam int PAD_W = REG_W - SEL_W - 2;

  logic             enReg, enNext;
  logic [SEL_W-1:0] selReg, selNext;
  logic [WIN_W-1:0] winCnt, winNext;
  logic             toeNow;
  logic             selChange;

  assign toeNow = (winCnt != '0);

  always_comb begin
    enNext  = enReg;
    selNext = selReg;
    winNext = toeNow ? WIN_W'(winCnt - 1'b1) : '0;
    if (wrEn) begin
      selNext = wrData[SEL_W-1:0];
      if (wrData[EN_BIT])  enNext = 1'b1;
      else if (toeNow)     enNext = 1'b0;
      if (wrData[TOE_BIT]) winNext = WIN_W'(UNLOCK_CYCLES);
      else                 winNext = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg  <= 1'b0;
      selReg <= '0;
      winCnt <= '0;
    end else begin
      enReg  <= enNext;
      selReg <= selNext;
      winCnt <= winNext;
    end
  end

  assign selChange      = wrEn && (wrData[SEL_W-1:0] != selReg);
  assign strobes.cntClr = kick || selChange || !enNext;
  assign strobes.cntInc = wdTick && enReg;
  assign strobes.limSel = selReg;
  assign rdData         = {{PAD_W{1'b0}}, toeNow, enReg, selReg};
endmodule

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2 = 14
) (
  input  logic        clk,
  input  logic        rstN,
  input  wdtStrobes_t strobes,
  output logic        rstReq
);
  localparam int CNT_W = BASE_LOG2 + (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] termMask;
  logic             hit;

  assign termMask = ~({CNT_W{1'b1}} << (BASE_LOG2 + int'(strobes.limSel)));
  assign hit      = strobes.cntInc && (cnt == termMask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      rstReq <= 1'b0;
    end else begin
      rstReq <= hit && !strobes.cntClr;
      if (strobes.cntClr || hit) cnt <= '0;
      else if (strobes.cntInc)   cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_timed_disable.sv
module wdt_timed_disable
  import wdt_pkg::*;
#(
  parameter int BASE_LOG2     = 14,
  parameter int UNLOCK_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic       kick,
  input  logic       wdTick,
  output logic       rstReq
);
  wdtStrobes_t strobes;

  wdt_ctrl #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .kick(kick), .wdTick(wdTick), .rdData(rdData), .strobes(strobes)
  );

  wdt_datapath #(.BASE_LOG2(BASE_LOG2)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rstReq(rstReq)
  );
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int UNLOCK_CYCLES = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic [7:0] rdData,
  input logic       kick,
  input logic       wdTick,
  input logic       rstReq
);
  int toeAge;

  always_ff @(posedge clk) begin
    if (!rstN)                    toeAge <= 0;
    else if (wrEn && wrData[4])   toeAge <= 0;
    else if (rdData[4])           toeAge <= toeAge + 1;
    else                          toeAge <= 0;
  end

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[7:5] == 3'b000); // R1
  AST_SEL_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> rdData[2:0] == $past(wrData[2:0])); // R2
  AST_EN_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[3] |=> rdData[3]); // R3
  AST_EN_LOCKED: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrData[3] && !rdData[4] |=> rdData[3] == $past(rdData[3])); // R4
  AST_TOE_SET: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrData[4] |=> rdData[4]); // R5
  AST_TOE_EXPIRE: assert property (@(posedge clk) disable iff (!rstN)
    rdData[4] |-> toeAge < UNLOCK_CYCLES); // R6
  AST_TOE_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && !wrData[4] |=> !rdData[4]); // R7
  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rstReq |=> !rstReq); // R8
  AST_KICK_NO_REQ: assert property (@(posedge clk) disable iff (!rstN)
    kick |=> !rstReq); // R9
  AST_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[3] |=> !rstReq); // R11
endmodule

bind wdt_timed_disable wdt_checker #(.UNLOCK_CYCLES(UNLOCK_CYCLES)) u_chk (.*);

// File: tb/tb_wdt_timed_disable.sv
`timescale 1ns/1ps
module tb_wdt_timed_disable;
  localparam int BASE = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       kick = 1'b0;
  logic       wdTick = 1'b1;
  logic       rstReq;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  wdt_timed_disable #(.BASE_LOG2(BASE), .UNLOCK_CYCLES(4)) dut (.*);

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // called at a negedge; the write lands on the following posedge
  task automatic wr(logic [7:0] d);
    wrEn = 1'b1; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic doKick();
    kick = 1'b1;
    @(negedge clk);
    kick = 1'b0;
  endtask

  // counts cycles from a cleared count until the request appears
  task automatic measure(string req, int exp);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!rstReq && n < 4096);
    check(req, n, exp);
  endtask

  task automatic noReqFor(string req, int cyc);
    int seen = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      if (rstReq) seen++;
    end
    check(req, seen, 0);
  endtask

  task automatic tReset();
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R2 reset value", rdData, 8'h00);
    check("R2 reset request", rstReq, 0);
  endtask

  task automatic tReserved();
    wr(8'hE5);
    check("R1 reserved bits", rdData, 8'h05);
    wr(8'h00);
    check("R2 select written", rdData, 8'h00);
  endtask

  task automatic tTimeout();
    wr(8'h08);
    check("R3 enable read", rdData, 8'h08);
    measure("R8 sel0 period", 1 << BASE);
    @(negedge clk);
    check("R8 pulse width", rstReq, 0);
    measure("R8 restart period", (1 << BASE) - 1);
    wr(8'h0A);
    measure("R8 sel2 period", 1 << (BASE + 2));
    repeat (20) @(negedge clk);
    wr(8'h0B);
    measure("R10 select change", 1 << (BASE + 3));
    wr(8'h0F);
    measure("R8 sel7 period", 1 << (BASE + 7));
  endtask

  task automatic tKick();
    wr(8'h08);
    repeat (10) @(negedge clk);
    doKick();
    measure("R9 kick restart", 1 << BASE);
    doKick();
    repeat (5) @(negedge clk);
    wdTick = 1'b0;
    repeat (20) @(negedge clk);
    wdTick = 1'b1;
    measure("R8 counts ticks only", (1 << BASE) - 5);
  endtask

  task automatic tLocked();
    wr(8'h00);
    check("R4 plain clear ignored", rdData, 8'h08);
  endtask

  task automatic tDisable();
    wr(8'h18);
    check("R5 unlock read", rdData, 8'h18);
    wr(8'h00);
    check("R5 disabled", rdData, 8'h00);
    noReqFor("R11 no request disabled", 3 << BASE);
  endtask

  task automatic tWindowEdge();
    wr(8'h08);
    wr(8'h18);
    repeat (3) @(negedge clk);
    check("R6 window still open", rdData[4], 1);
    wr(8'h00);
    check("R6 fourth cycle accepted", rdData, 8'h00);
    wr(8'h08);
    wr(8'h18);
    repeat (4) @(negedge clk);
    check("R6 window self-cleared", rdData[4], 0);
    wr(8'h00);
    check("R6 fifth cycle refused", rdData, 8'h08);
  endtask

  task automatic tClose();
    wr(8'h18);
    wr(8'h08);
    check("R7 window closed", rdData, 8'h08);
    wr(8'h00);
    check("R7 clear after close", rdData, 8'h08);
  endtask

  task automatic tHeldZero();
    doKick();
    repeat (10) @(negedge clk);
    wr(8'h18);
    wr(8'h00);
    noReqFor("R11 quiet while off", 30);
    wr(8'h08);
    measure("R11 full period after enable", 1 << BASE);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    tReset();
    tReserved();
    tTimeout();
    tKick();
    tLocked();
    tDisable();
    tWindowEdge();
    tClose();
    tHeldZero();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule